// File: doc/BRIEF.md
# RTC Prescaler and Subsecond Timebase

This block turns a slow real-time-clock kernel clock into the timing events a calendar needs. Two programmable dividers are chained. The first is a short divider with a 7-bit limit, and it produces an enable pulse once every (limit+1) kernel cycles. The second stage is a subsecond down-counter that advances only on those pulses. In calendar mode this counter reloads from a 15-bit limit each time it empties, and each reload produces a calendar tick. Both ticks are single-cycle enables in the kernel clock domain; neither is a derived clock.

A two-bit mode field selects how the counter behaves. Calendar mode (00) is the reloading counter described above. Binary mode (01) turns it into a 32-bit free-running down-counter, suppresses the calendar tick and drops the calendar-enable flag. The two mixed codes (10 and 11) use the same 32-bit free-running counter but keep the calendar alive: a calendar tick is issued whenever the low byte of the counter rolls under. The divider limits and the mode are sampled only on a synchronous init pulse. That pulse also restarts the first divider and preloads the counter, so software can change the inputs at any time without disturbing the running timebase.

Top module: `rtcpre_timebase`

## Requirements
- R1: `apre_tick` is high for exactly one cycle every (A+1) cycles, where A is the first-stage limit captured at the last init. After an init edge, the first pulse is visible A+1 cycles later.
- R2: In calendar mode (code 00), init loads `subsec` with the captured second-stage limit S. Each `apre_tick` then decrements it. A pulse that finds it at 0 reloads S and raises `spre_tick` in that same cycle, so `spre_tick` repeats every (A+1)*(S+1) cycles.
- R3: Out of reset, the limits are A=127 and S=255 in calendar mode, so `spre_tick` fires once every 32768 cycles. The first one comes exactly 32768 cycles after reset is released.
- R4: In binary (01) and mixed (10, 11) modes, init clears `subsec` to 0. Each `apre_tick` then decrements all 32 bits, and the step from 0 wraps to 0xFFFFFFFF without a reload.
- R5: In binary mode, `spre_tick` and `cal_en` stay low and the value of S has no effect on `subsec`.
- R6: In mixed mode, `cal_en` stays high. `spre_tick` rises together with the `apre_tick` whose decrement takes the low 8 bits of `subsec` from 0x00 to 0xFF.
- R7: Changes on `cfg_adiv`, `cfg_sdiv` or `cfg_mode` have no effect until `init` is high at a clock edge. At that edge both ticks drop to 0 and the first divider restarts from zero.
- R8: During and right after reset, `apre_tick` and `spre_tick` are 0, `subsec` is 255 and `cal_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RTC kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init | input | 1 | Synchronous init pulse; captures configuration and restarts the timebase |
| cfg_adiv | input | 7 | First-stage divider limit A (divide by A+1) |
| cfg_sdiv | input | 15 | Second-stage reload limit S (calendar mode) |
| cfg_mode | input | 2 | 00 calendar, 01 binary, 10/11 mixed |
| apre_tick | output | 1 | First-stage enable pulse |
| spre_tick | output | 1 | Calendar enable pulse |
| subsec | output | 32 | Subsecond down-counter value |
| cal_en | output | 1 | High when the calendar is functional |

## Verification
Calendar mode is swept over every combination of A and S from 0 to 3. The predicted `apre_tick`, `spre_tick` and `subsec` are compared on every cycle. This separates a wrong divide ratio in either stage, an off-by-one reload, and a tick that is misaligned with its stage. Binary mode is run with several A values and with two different S values to show that S is ignored and that the counter wraps on the first step after init. Mixed mode is run long enough to cover two low-byte roll-unders. In every case the configuration inputs are scrambled right after init to expose any path that reads them directly. A long run from reset with the default limits confirms the 32768-cycle calendar period.

// File: rtl/rtcpre_pkg.sv
package rtcpre_pkg;
  typedef enum logic [1:0] {
    MODE_CAL   = 2'b00,
    MODE_BIN   = 2'b01,
    MODE_MIX_A = 2'b10,
    MODE_MIX_B = 2'b11
  } tick_mode_e;

  // Counter runs without reload in binary and mixed modes
  function automatic logic mode_free_running(input logic [1:0] m);
    return m != MODE_CAL;
  endfunction

  // Calendar stays functional in every mode except binary
  function automatic logic mode_calendar_on(input logic [1:0] m);
    return m != MODE_BIN;
  endfunction

  // Mixed modes derive the calendar tick from low-byte roll-under
  function automatic logic mode_mixed(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/rtcpre_cfg_shadow.sv
module rtcpre_cfg_shadow #(
  parameter int ADIV_W   = 7,
  parameter int SDIV_W   = 15,
  parameter int RST_ADIV = 127,
  parameter int RST_SDIV = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADIV_W-1:0] in_adiv,
  input  logic [SDIV_W-1:0] in_sdiv,
  input  logic [1:0]        in_mode,
  output logic [ADIV_W-1:0] out_adiv,
  output logic [SDIV_W-1:0] out_sdiv,
  output logic [1:0]        out_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_adiv <= ADIV_W'(RST_ADIV);
      out_sdiv <= SDIV_W'(RST_SDIV);
      out_mode <= rtcpre_pkg::MODE_CAL;
    end else if (load) begin
      out_adiv <= in_adiv;
      out_sdiv <= in_sdiv;
      out_mode <= in_mode;
    end
  end
endmodule

// File: rtl/rtcpre_async_div.sv
module rtcpre_async_div #(
  parameter int ADIV_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADIV_W-1:0] limit,
  output logic              evt,
  output logic              tick
);
  logic [ADIV_W-1:0] cnt;

  assign evt = !clr && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= evt;
      if (clr || evt) cnt <= '0;
      else            cnt <= cnt + ADIV_W'(1);
    end
  end
endmodule

// File: rtl/rtcpre_subsec_ctr.sv
module rtcpre_subsec_ctr #(
  parameter int SUB_W    = 32,
  parameter int SDIV_W   = 15,
  parameter int ROLL_W   = 8,
  parameter int RST_SDIV = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        load_mode,
  input  logic [SDIV_W-1:0] load_sdiv,
  input  logic              step,
  input  logic [1:0]        run_mode,
  input  logic [SDIV_W-1:0] run_sdiv,
  output logic [SUB_W-1:0]  count,
  output logic              reload_evt,
  output logic              roll_evt,
  output logic              cal_tick
);
  import rtcpre_pkg::*;

  localparam logic [SUB_W-1:0] ONE = SUB_W'(1);

  logic run_free;
  logic at_zero;

  assign run_free   = mode_free_running(run_mode);
  assign at_zero    = (count == '0);
  assign reload_evt = step && !load && !run_free && at_zero;
  assign roll_evt   = step && !load && mode_mixed(run_mode) &&
                      (count[ROLL_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= SUB_W'(RST_SDIV);
      cal_tick <= 1'b0;
    end else if (load) begin
      count    <= mode_free_running(load_mode) ? '0 : SUB_W'(load_sdiv);
      cal_tick <= 1'b0;
    end else if (step) begin
      if (reload_evt) count <= SUB_W'(run_sdiv);
      else            count <= count - ONE;
      cal_tick <= reload_evt || roll_evt;
    end else begin
      cal_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rtcpre_timebase.sv
module rtcpre_timebase #(
  parameter int ADIV_W   = 7,
  parameter int SDIV_W   = 15,
  parameter int SUB_W    = 32,
  parameter int ROLL_W   = 8,
  parameter int RST_ADIV = 127,
  parameter int RST_SDIV = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ADIV_W-1:0] cfg_adiv,
  input  logic [SDIV_W-1:0] cfg_sdiv,
  input  logic [1:0]        cfg_mode,
  output logic              apre_tick,
  output logic              spre_tick,
  output logic [SUB_W-1:0]  subsec,
  output logic              cal_en
);
  import rtcpre_pkg::*;

  logic [ADIV_W-1:0] adiv_q;
  logic [SDIV_W-1:0] sdiv_q;
  logic [1:0]        mode_q;
  logic              apre_evt;
  logic              reload_evt;
  logic              roll_evt;

  rtcpre_cfg_shadow #(
    .ADIV_W(ADIV_W), .SDIV_W(SDIV_W),
    .RST_ADIV(RST_ADIV), .RST_SDIV(RST_SDIV)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(init),
    .in_adiv(cfg_adiv), .in_sdiv(cfg_sdiv), .in_mode(cfg_mode),
    .out_adiv(adiv_q), .out_sdiv(sdiv_q), .out_mode(mode_q)
  );

  rtcpre_async_div #(.ADIV_W(ADIV_W)) u_adiv (
    .clk(clk), .rst_n(rst_n), .clr(init), .limit(adiv_q),
    .evt(apre_evt), .tick(apre_tick)
  );

  rtcpre_subsec_ctr #(
    .SUB_W(SUB_W), .SDIV_W(SDIV_W), .ROLL_W(ROLL_W), .RST_SDIV(RST_SDIV)
  ) u_sub (
    .clk(clk), .rst_n(rst_n),
    .load(init), .load_mode(cfg_mode), .load_sdiv(cfg_sdiv),
    .step(apre_evt), .run_mode(mode_q), .run_sdiv(sdiv_q),
    .count(subsec), .reload_evt(reload_evt), .roll_evt(roll_evt),
    .cal_tick(spre_tick)
  );

  assign cal_en = mode_calendar_on(mode_q);
endmodule

// File: rtl/rtcpre_checker.sv
module rtcpre_checker #(
  parameter int SDIV_W = 15,
  parameter int SUB_W  = 32,
  parameter int ROLL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic              apre_evt,
  input logic [1:0]        mode_q,
  input logic [SDIV_W-1:0] sdiv_q,
  input logic              apre_tick,
  input logic              spre_tick,
  input logic [SUB_W-1:0]  subsec,
  input logic              cal_en
);
  assert_spre_needs_apre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spre_tick |-> apre_tick);

  assert_cal_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && apre_evt && mode_q == 2'b00 && subsec == '0)
      |=> (subsec == SUB_W'($past(sdiv_q)) && spre_tick));

  assert_cal_high_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> (subsec[SUB_W-1:SDIV_W] == '0));

  assert_free_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && apre_evt && mode_q != 2'b00) |=> (subsec == $past(subsec) - SUB_W'(1)));

  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !apre_evt) |=> $stable(subsec));

  assert_bin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01) |-> (!spre_tick && !cal_en));

  assert_mix_roll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && apre_evt && mode_q[1] && subsec[ROLL_W-1:0] == '0) |=> spre_tick);

  assert_init_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!apre_tick && !spre_tick));

  assert_single_spre_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spre_tick && mode_q != 2'b00) |=> !spre_tick);
endmodule

bind rtcpre_timebase rtcpre_checker #(
  .SDIV_W(SDIV_W), .SUB_W(SUB_W), .ROLL_W(ROLL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .apre_evt(apre_evt),
  .mode_q(mode_q), .sdiv_q(sdiv_q), .apre_tick(apre_tick),
  .spre_tick(spre_tick), .subsec(subsec), .cal_en(cal_en)
);

// File: tb/sim_rtcpre_timebase.sv
module sim_rtcpre_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic [6:0]  cfg_adiv = '0;
  logic [14:0] cfg_sdiv = '0;
  logic [1:0]  cfg_mode = '0;
  logic        apre_tick, spre_tick, cal_en;
  logic [31:0] subsec;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rtcpre_timebase u0 (
    .clk(clk), .rst_n(rst_n), .init(init),
    .cfg_adiv(cfg_adiv), .cfg_sdiv(cfg_sdiv), .cfg_mode(cfg_mode),
    .apre_tick(apre_tick), .spre_tick(spre_tick),
    .subsec(subsec), .cal_en(cal_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Pulse init with a configuration, scramble the inputs, then predict each cycle
  task automatic run_case(input int a, input int s, input int m, input int ncyc);
    string rq;
    @(negedge clk);
    cfg_adiv = 7'(a); cfg_sdiv = 15'(s); cfg_mode = 2'(m); init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    cfg_adiv = 7'(a) ^ 7'h05; cfg_sdiv = 15'(s) ^ 15'h0003; cfg_mode = 2'(m) ^ 2'b01;
    chk("R7", "apre after init", 32'(apre_tick), 0);
    chk("R7", "spre after init", 32'(spre_tick), 0);
    chk(m == 0 ? "R2" : "R4", "subsec preload", subsec, m == 0 ? 32'(s) : 32'h0);
    for (int k = 1; k <= ncyc; k++) begin
      int n;
      logic ea, es, ec;
      logic [31:0] ev;
      @(negedge clk);
      n  = k / (a + 1);
      ea = (k % (a + 1)) == 0;
      if (m == 0) begin
        rq = "R2";
        ev = 32'(s - (n % (s + 1)));
        es = ea && (n % (s + 1)) == 0;
        ec = 1'b1;
      end else if (m == 1) begin
        rq = "R5";
        ev = 32'h0 - 32'(n);
        es = 1'b0;
        ec = 1'b0;
      end else begin
        rq = "R6";
        ev = 32'h0 - 32'(n);
        es = ea && ((n - 1) % 256) == 0;
        ec = 1'b1;
      end
      chk("R1", "apre_tick", 32'(apre_tick), 32'(ea));
      chk(rq, "spre_tick", 32'(spre_tick), 32'(es));
      chk(m == 0 ? "R2" : "R4", "subsec", subsec, ev);
      chk(rq, "cal_en", 32'(cal_en), 32'(ec));
    end
  endtask

  initial begin
    int spre_count;
    int first_spre;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "apre reset", 32'(apre_tick), 0);
    chk("R8", "spre reset", 32'(spre_tick), 0);
    chk("R8", "subsec reset", subsec, 32'd255);
    chk("R8", "cal_en reset", 32'(cal_en), 1);
    rst_n = 1'b1;
    chk("R8", "subsec after release", subsec, 32'd255);
    // R3: default limits give one calendar tick per 32768 cycles
    spre_count = 0;
    first_spre = -1;
    for (int k = 1; k <= 65536; k++) begin
      @(negedge clk);
      if (spre_tick) begin
        spre_count++;
        if (first_spre < 0) first_spre = k;
      end
    end
    chk("R3", "first spre cycle", 32'(first_spre), 32'd32768);
    chk("R3", "spre count in 65536", 32'(spre_count), 32'd2);
    // R1/R2/R7: calendar sweep
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 4; s++)
        run_case(a, s, 0, 2 * (a + 1) * (s + 1) + 3);
    // R4/R5: binary, two S values must give identical behaviour
    for (int a = 0; a < 3; a++) run_case(a, 0, 1, 12);
    run_case(1, 9, 1, 12);
    run_case(2, 32767, 1, 12);
    // R6: both mixed codes
    run_case(0, 0, 2, 600);
    run_case(1, 5, 3, 600);
    // R7: back to calendar from a free-running mode
    run_case(2, 1, 0, 20);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule